// File: doc/BRIEF.md
# Paired-Block Signature Verifier

This block checks the integrity of instruction blocks that share one stored signature per pair. Two neighbouring blocks form a pair: block addresses that differ only in bit 0. The pair's signature is the XOR of every sub-block signature word of both blocks. An external MAC datapath streams in the sub-block signatures of a newly fetched block. The verifier folds them into that block's own contribution. It then needs the partner block's contribution, and it takes that from a small tagged cache of recently verified contributions. If the partner is not cached, it asks the fetch side for it. The verifier compares the XOR of both contributions with the stored signature and reports the verdict.

A verification starts with a request carrying the block address and the stored pair signature. The request, sub-signature and partner-return channels are valid/ready streams. A transfer happens on a clock edge where both valid and ready are high. The verifier holds a ready low whenever it cannot take data, and a source must keep its valid and data steady until the transfer happens. The verdict is a one-cycle pulse with no back-pressure.

Top module: `sigpair_verifier`

## Requirements
- R1: After reset, req_ready is 1, and busy, sub_ready, pfetch_req and res_valid are 0. The contribution cache is empty.
- R2: A request is taken only while req_ready is 1. From the edge that takes it until the verdict edge, req_ready is 0 and busy is 1. A request offered in that window is not taken and does not change the pending verdict.
- R3: After a request is taken, sub_ready is 1 until exactly SUBS_PER_BLK sub-signatures have been transferred. Cycles with sub_valid low only delay the collection.
- R4: The block's own contribution is the XOR of its sub-signatures. res_match is 1 when own XOR partner contribution equals the stored signature, and 0 otherwise.
- R5: The partner is the block address with bit 0 inverted. A cache entry supplies the partner when its stored address bits [ADDR_W-1:1] equal the current block's bits and its stored bit 0 is the partner's bit 0.
- R6: On a cache hit, res_valid is 1 in the cycle after the edge that transfers the last sub-signature, and pfetch_req stays 0.
- R7: On a cache miss, pfetch_req is 1 and pfetch_addr is the partner address from the cycle after the last sub-signature until the partner-return transfer. ptr_ready equals pfetch_req. res_valid is 1 in the cycle after that transfer.
- R8: A verification that ends in a match stores the block's own contribution in the cache. A mismatch stores nothing.
- R9: The cache holds OBUF_DEPTH entries and is filled and overwritten in round-robin order. The (OBUF_DEPTH+1)-th store after reset evicts the first one.
- R10: res_valid is high for exactly one cycle per verification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Verification request offered |
| req_ready | output | 1 | Verifier idle, request can be taken |
| req_addr | input | ADDR_W | Block address of the fetched block |
| req_sig | input | SIG_W | Stored signature of the block pair |
| busy | output | 1 | Verification in progress |
| sub_valid | input | 1 | Sub-block signature offered |
| sub_ready | output | 1 | Sub-block signature can be taken |
| sub_sig | input | SIG_W | Sub-block signature word |
| pfetch_req | output | 1 | Partner contribution needed |
| pfetch_addr | output | ADDR_W | Address of the partner block |
| ptr_valid | input | 1 | Partner contribution offered |
| ptr_ready | output | 1 | Partner contribution can be taken |
| ptr_sig | input | SIG_W | Partner block's contribution |
| res_valid | output | 1 | Verdict pulse |
| res_match | output | 1 | Verdict: 1 match, 0 mismatch |

## Verification
On a cache hit the verdict appears one cycle after the edge that takes the last sub-signature. On a miss it appears one cycle after the edge that takes the partner contribution, and the fetch request holds in between. The bench drives inputs on falling edges. It checks res_valid, pfetch_req and pfetch_addr at the falling edge right after each of those edges. A bench model of the cache predicts hit or miss for each block. A monitor compares each verdict pulse, at the falling edge, against a queue of expected match values.

// File: rtl/sigpair_pkg.sv
package sigpair_pkg;
  typedef enum logic [1:0] {
    VS_IDLE    = 2'd0,
    VS_COLLECT = 2'd1,
    VS_WAIT    = 2'd2
  } vstate_e;
endpackage

// File: rtl/sigpair_accum.sv
module sigpair_accum #(
  parameter int SIG_W = 32,
  parameter int SUBS  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             take,
  input  logic [SIG_W-1:0] sub_sig,
  output logic             last,
  output logic [SIG_W-1:0] own_sig
);
  localparam int CNT_W = (SUBS > 1) ? $clog2(SUBS) : 1;

  logic [CNT_W-1:0] cnt;
  logic [SIG_W-1:0] acc;

  assign last    = (cnt == CNT_W'(SUBS - 1));
  assign own_sig = acc ^ sub_sig;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      cnt <= '0;
      acc <= '0;
    end else if (take) begin
      cnt <= last ? '0 : cnt + CNT_W'(1);
      acc <= own_sig;
    end
  end

  // R3: after the final word the count restarts
  p_count_wraps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && last && !clear) |=> (cnt == '0));
endmodule

// File: rtl/sigpair_obuf.sv
module sigpair_obuf #(
  parameter int SIG_W = 32,
  parameter int TAG_W = 11,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAG_W-1:0] lk_tag,
  input  logic             lk_half,
  output logic             lk_hit,
  output logic [SIG_W-1:0] lk_data,
  input  logic             ins_en,
  input  logic [TAG_W-1:0] ins_tag,
  input  logic             ins_half,
  input  logic [SIG_W-1:0] ins_data
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] ent_v;
  logic [DEPTH-1:0] ent_half;
  logic [TAG_W-1:0] ent_tag  [DEPTH];
  logic [SIG_W-1:0] ent_data [DEPTH];
  logic [DEPTH-1:0] hit_vec;
  logic [PTR_W-1:0] rr_ptr;

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_v[gi]    <= 1'b0;
        ent_half[gi] <= 1'b0;
        ent_tag[gi]  <= '0;
        ent_data[gi] <= '0;
      end else if (ins_en && rr_ptr == PTR_W'(gi)) begin
        ent_v[gi]    <= 1'b1;
        ent_half[gi] <= ins_half;
        ent_tag[gi]  <= ins_tag;
        ent_data[gi] <= ins_data;
      end
    end
    assign hit_vec[gi] = ent_v[gi] && (ent_tag[gi] == lk_tag) && (ent_half[gi] == lk_half);
  end

  always_comb begin
    lk_hit  = |hit_vec;
    lk_data = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (hit_vec[i]) lk_data = ent_data[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rr_ptr <= '0;
    else if (ins_en) rr_ptr <= (rr_ptr == PTR_W'(DEPTH - 1)) ? '0 : rr_ptr + PTR_W'(1);
  end

  // R9: the slot under the pointer becomes valid after a store
  p_store_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ins_en |=> ent_v[$past(rr_ptr)]);
  // R8: a hit is only possible for a slot that was stored
  p_hit_needs_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (ent_v != '0));
endmodule

// File: rtl/sigpair_verifier.sv
module sigpair_verifier
  import sigpair_pkg::*;
#(
  parameter int SIG_W        = 32,
  parameter int ADDR_W       = 12,
  parameter int SUBS_PER_BLK = 2,
  parameter int OBUF_DEPTH   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SIG_W-1:0]  req_sig,
  output logic              busy,
  input  logic              sub_valid,
  output logic              sub_ready,
  input  logic [SIG_W-1:0]  sub_sig,
  output logic              pfetch_req,
  output logic [ADDR_W-1:0] pfetch_addr,
  input  logic              ptr_valid,
  output logic              ptr_ready,
  input  logic [SIG_W-1:0]  ptr_sig,
  output logic              res_valid,
  output logic              res_match
);
  localparam int TAG_W = ADDR_W - 1;

  vstate_e           state;
  logic [ADDR_W-1:0] addr_r;
  logic [SIG_W-1:0]  stored_r;
  logic [SIG_W-1:0]  own_r;
  logic              req_fire, sub_fire, ptr_fire;
  logic              last, lk_hit, hit_done, miss_done, fin, verdict;
  logic [SIG_W-1:0]  own_sig, lk_data;

  assign req_ready   = (state == VS_IDLE);
  assign busy        = !req_ready;
  assign sub_ready   = (state == VS_COLLECT);
  assign ptr_ready   = (state == VS_WAIT);
  assign pfetch_req  = ptr_ready;
  assign pfetch_addr = addr_r ^ ADDR_W'(1);

  assign req_fire  = req_valid && req_ready;
  assign sub_fire  = sub_valid && sub_ready;
  assign ptr_fire  = ptr_valid && ptr_ready;
  assign hit_done  = sub_fire && last && lk_hit;
  assign miss_done = sub_fire && last && !lk_hit;
  assign fin       = hit_done || ptr_fire;

  always_comb begin
    if (hit_done) verdict = ((own_sig ^ lk_data) == stored_r);
    else          verdict = ((own_r ^ ptr_sig) == stored_r);
  end

  sigpair_accum #(.SIG_W(SIG_W), .SUBS(SUBS_PER_BLK)) u_accum (
    .clk(clk), .rst_n(rst_n), .clear(req_fire), .take(sub_fire),
    .sub_sig(sub_sig), .last(last), .own_sig(own_sig)
  );

  sigpair_obuf #(.SIG_W(SIG_W), .TAG_W(TAG_W), .DEPTH(OBUF_DEPTH)) u_obuf (
    .clk(clk), .rst_n(rst_n),
    .lk_tag(addr_r[ADDR_W-1:1]), .lk_half(~addr_r[0]),
    .lk_hit(lk_hit), .lk_data(lk_data),
    .ins_en(fin && verdict), .ins_tag(addr_r[ADDR_W-1:1]), .ins_half(addr_r[0]),
    .ins_data(hit_done ? own_sig : own_r)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= VS_IDLE;
      addr_r    <= '0;
      stored_r  <= '0;
      own_r     <= '0;
      res_valid <= 1'b0;
      res_match <= 1'b0;
    end else begin
      res_valid <= fin;
      if (fin) res_match <= verdict;
      case (state)
        VS_IDLE: if (req_fire) begin
          addr_r   <= req_addr;
          stored_r <= req_sig;
          state    <= VS_COLLECT;
        end
        VS_COLLECT: begin
          if (hit_done) state <= VS_IDLE;
          else if (miss_done) begin
            own_r <= own_sig;
            state <= VS_WAIT;
          end
        end
        VS_WAIT: if (ptr_fire) state <= VS_IDLE;
        default: state <= VS_IDLE;
      endcase
    end
  end

  // R10: verdict is a single-cycle pulse
  p_one_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  // R6/R7: a verdict follows the last sub-signature or the partner return
  p_verdict_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> $past(sub_fire || ptr_fire));
  // R7: a fetch request begins only after the last sub-signature transfer
  p_fetch_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pfetch_req) |-> $past(sub_fire));
  // R2/R3: a taken request opens collection and blocks new ones
  p_take_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> (sub_ready && busy));
endmodule

// File: tb/sigpair_verifier_bench.sv
module sigpair_verifier_bench;
  localparam int SIG_W = 32;
  localparam int ADDR_W = 12;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, sub_valid = 1'b0, ptr_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [SIG_W-1:0] req_sig = '0, sub_sig = '0, ptr_sig = '0;
  logic req_ready, busy, sub_ready, pfetch_req, ptr_ready, res_valid, res_match;
  logic [ADDR_W-1:0] pfetch_addr;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  bit exp_q[$];

  bit m_v[DEPTH];
  logic [ADDR_W-1:0] m_addr[DEPTH];
  int m_ptr = 0;

  always #5 clk = ~clk;

  sigpair_verifier #(.SIG_W(SIG_W), .ADDR_W(ADDR_W), .SUBS_PER_BLK(2), .OBUF_DEPTH(DEPTH)) u_sigpair_verifier (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_sig(req_sig), .busy(busy),
    .sub_valid(sub_valid), .sub_ready(sub_ready), .sub_sig(sub_sig),
    .pfetch_req(pfetch_req), .pfetch_addr(pfetch_addr),
    .ptr_valid(ptr_valid), .ptr_ready(ptr_ready), .ptr_sig(ptr_sig),
    .res_valid(res_valid), .res_match(res_match)
  );

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [SIG_W-1:0] contrib(input logic [ADDR_W-1:0] a);
    return {a, 4'h5, ~a, 4'hA} ^ 32'h3C96_1E87;
  endfunction

  function automatic bit model_hit(input logic [ADDR_W-1:0] a);
    for (int i = 0; i < DEPTH; i++)
      if (m_v[i] && m_addr[i] == (a ^ ADDR_W'(1))) return 1'b1;
    return 1'b0;
  endfunction

  // Scoreboard monitor (R4, R10)
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R10 unexpected verdict", 32'(res_valid), 32'd0);
      else begin
        bit e;
        e = exp_q.pop_front();
        chk(res_match == e, "R4 verdict", 32'(res_match), 32'(e));
      end
    end
  end

  task automatic run_block(input logic [ADDR_W-1:0] a, input bit good, input bit stall, input bit poke);
    logic [SIG_W-1:0] s0, s1;
    bit hit;
    s0 = 32'h1234_5678 ^ {20'd0, a};
    s1 = contrib(a) ^ s0;
    hit = model_hit(a);
    exp_q.push_back(good);
    req_valid = 1'b1;
    req_addr = a;
    req_sig = contrib(a) ^ contrib(a ^ ADDR_W'(1)) ^ (good ? 32'd0 : 32'h0000_0100);
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    chk(busy && !req_ready, "R2 busy after take", {30'd0, busy, req_ready}, 32'd2);
    sub_valid = 1'b1; sub_sig = s0;
    @(posedge clk); @(negedge clk);
    if (stall) begin
      sub_valid = 1'b0;
      @(posedge clk); @(negedge clk);
      chk(sub_ready, "R3 still collecting after stall", 32'(sub_ready), 32'd1);
    end
    if (poke) begin
      req_valid = 1'b1; req_sig = ~req_sig;
      chk(!req_ready && busy, "R2 request refused while busy", 32'(req_ready), 32'd0);
    end
    sub_valid = 1'b1; sub_sig = s1;
    @(posedge clk); @(negedge clk);
    sub_valid = 1'b0; req_valid = 1'b0;
    chk(!sub_ready, "R3 collection closed", 32'(sub_ready), 32'd0);
    if (hit) begin
      chk(res_valid && !pfetch_req, "R6 hit verdict timing", {30'd0, res_valid, pfetch_req}, 32'd2);
    end else begin
      chk(pfetch_req && !res_valid, "R7 fetch raised", {30'd0, pfetch_req, res_valid}, 32'd2);
      chk(pfetch_addr == (a ^ ADDR_W'(1)), "R5 partner address", 32'(pfetch_addr), 32'(a ^ ADDR_W'(1)));
      @(posedge clk); @(negedge clk);
      chk(pfetch_req && ptr_ready && !res_valid, "R7 fetch held", {31'd0, pfetch_req}, 32'd1);
      ptr_valid = 1'b1; ptr_sig = contrib(a ^ ADDR_W'(1));
      @(posedge clk); @(negedge clk);
      ptr_valid = 1'b0;
      chk(res_valid && !pfetch_req, "R7 verdict after partner", {30'd0, res_valid, pfetch_req}, 32'd2);
    end
    @(posedge clk); @(negedge clk);
    chk(!res_valid && req_ready, "R10 pulse ends, idle", {30'd0, res_valid, req_ready}, 32'd1);
    if (good) begin
      m_v[m_ptr] = 1'b1; m_addr[m_ptr] = a;
      m_ptr = (m_ptr + 1) % DEPTH;
    end
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) m_v[i] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !busy && !sub_ready && !pfetch_req && !res_valid, "R1 reset state",
        {27'd0, req_ready, busy, sub_ready, pfetch_req, res_valid}, 32'h10);
    run_block(12'h010, 1'b1, 1'b0, 1'b0);  // R7 miss on empty cache, match
    run_block(12'h011, 1'b1, 1'b1, 1'b0);  // R5 R6 hit on stored partner, stall R3
    run_block(12'h010, 1'b0, 1'b0, 1'b1);  // R4 mismatch on hit, R2 poke
    run_block(12'h030, 1'b0, 1'b0, 1'b0);  // R8 mismatch not stored
    run_block(12'h031, 1'b1, 1'b0, 1'b0);  // R8 partner absent -> miss
    run_block(12'h040, 1'b1, 1'b0, 1'b0);  // fills the fourth slot
    run_block(12'h050, 1'b1, 1'b1, 1'b0);  // R9 evicts 0x010
    run_block(12'h011, 1'b1, 1'b0, 1'b0);  // R9 partner evicted -> miss
    run_block(12'h041, 1'b0, 1'b0, 1'b0);  // R4 hit with wrong stored
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R10 all verdicts seen", 32'(exp_q.size()), 32'd0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule